// File: doc/BRIEF.md
# Sleep-Enable SMI Trigger Register

This block is a small byte-wide register unit placed on an I/O register bus. Two neighbouring byte locations form a 16-bit power-management control register that software may access as one word. The upper byte holds a three-bit sleep-type field and a sleep-enable bit. The sleep-type field is storage only and drives nothing.

Writing a one to the sleep-enable bit does not start any sleep sequence. It records a sticky event in a status register. If the matching bit of an enable register is also set, the block asserts a system management interrupt (SMI) output. Firmware handling the SMI reads the status register, does the sleep work in software, and clears the event by writing a one to the status bit. The sleep-enable bit clears itself, so every new write of one gives a new event.

The block decodes a single offset per bus cycle and returns read data combinationally while the read strobe is high.

Top module: `sleep_smi_regs`

## Requirements
- R1: After reset, the sleep-type field, the status bit and the enable bit are all zero, and `smiOut` is low.
- R2: Bits 4:2 at offset 0x61 are a read/write sleep-type field. A read of 0x61 returns that field in bits 4:2 and zero in every other bit.
- R3: A write to offset 0x61 with bit 5 set sets the status bit, which is bit 5 at offset 0x64. This happens whatever the value of the enable bit.
- R4: The sleep-enable bit, bit 5 at offset 0x61, always reads back as zero.
- R5: Bit 5 at offset 0x66 is a read/write SMI enable bit.
- R6: `smiOut` is high exactly while the status bit and the enable bit are both one. It rises in the cycle after the write that completes that condition.
- R7: A write to 0x64 with bit 5 set clears the status bit. A write to 0x64 with bit 5 clear leaves the status bit unchanged.
- R8: A write to 0x61 with bit 5 clear changes only the sleep-type field. It leaves the status bit and `smiOut` unchanged.
- R9: Offset 0x60, every unmapped offset, and every bit other than those named above read as zero and ignore writes.
- R10: `regRdata` is zero whenever `regRd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 8 | Byte offset from the block's base |
| regWr | input | 1 | Write strobe, one cycle per write |
| regRd | input | 1 | Read strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, valid while `regRd` is high |
| smiOut | output | 1 | SMI request, active high |

## Verification
Two functions act on the one status flop: the trigger that sets it, and the write-one-to-clear that resets it. The bench drives them on adjacent bus cycles. With the enable bit on, it writes a trigger, writes a clear on the next cycle, and then writes another trigger at once.

After each write, `smiOut` must follow the expected status-and-enable value. After the clear it must fall, and after the second trigger it must rise again. This shows that a clear does not block the next set, and that a set does not survive the clear that follows it.

// File: rtl/sleep_smi_pkg.sv
package sleep_smi_pkg;

  typedef enum logic [2:0] {
    RD_NONE    = 3'd0,
    RD_CTRL_LO = 3'd1,
    RD_CTRL_HI = 3'd2,
    RD_STATUS  = 3'd3,
    RD_ENABLE  = 3'd4
  } rdSel_e;

  typedef struct packed {
    logic   wrSlpType;
    logic   slpTrig;
    logic   clrStatus;
    logic   wrEnable;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/sleep_smi_ctrl.sv
module sleep_smi_ctrl
  import sleep_smi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] OFF_CTRL_LO = 'h60,
  parameter logic [ADDR_W-1:0] OFF_CTRL_HI = 'h61,
  parameter logic [ADDR_W-1:0] OFF_STATUS  = 'h64,
  parameter logic [ADDR_W-1:0] OFF_ENABLE  = 'h66,
  parameter int SLP_EN_BIT = 5,
  parameter int EVT_BIT    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output strobe_t           strobes
);

  logic hitLo, hitHi, hitStat, hitEn;

  assign hitLo   = (regAddr == OFF_CTRL_LO);
  assign hitHi   = (regAddr == OFF_CTRL_HI);
  assign hitStat = (regAddr == OFF_STATUS);
  assign hitEn   = (regAddr == OFF_ENABLE);

  always_comb begin
    strobes           = '0;
    strobes.rdSel     = RD_NONE;
    strobes.wrSlpType = regWr && hitHi;
    strobes.slpTrig   = regWr && hitHi && regWdata[SLP_EN_BIT];
    strobes.clrStatus = regWr && hitStat && regWdata[EVT_BIT];
    strobes.wrEnable  = regWr && hitEn;
    if (regRd) begin
      if (hitLo)        strobes.rdSel = RD_CTRL_LO;
      else if (hitHi)   strobes.rdSel = RD_CTRL_HI;
      else if (hitStat) strobes.rdSel = RD_STATUS;
      else if (hitEn)   strobes.rdSel = RD_ENABLE;
    end
  end

  // R9: one write strobe family at most per cycle
  a_r9_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrSlpType, strobes.clrStatus, strobes.wrEnable}));

  // R10: no read selection without read strobe
  a_r10_no_sel_idle: assert property (@(posedge clk) disable iff (!rstN)
    !regRd |-> strobes.rdSel == RD_NONE);

endmodule

// File: rtl/sleep_smi_dp.sv
module sleep_smi_dp
  import sleep_smi_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SLPTYP_LSB  = 2,
  parameter int SLPTYP_W    = 3,
  parameter int EVT_BIT     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              statusQ,
  output logic              enableQ
);

  localparam int SLPTYP_MSB = SLPTYP_LSB + SLPTYP_W - 1;

  logic [SLPTYP_W-1:0] slpTypeQ;
  logic [DATA_W-1:0]   hiView, statView, enView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slpTypeQ <= '0;
      statusQ  <= 1'b0;
      enableQ  <= 1'b0;
    end else begin
      if (strobes.wrSlpType) slpTypeQ <= regWdata[SLPTYP_MSB:SLPTYP_LSB];
      if (strobes.wrEnable)  enableQ  <= regWdata[EVT_BIT];
      if (strobes.slpTrig)        statusQ <= 1'b1;
      else if (strobes.clrStatus) statusQ <= 1'b0;
    end
  end

  always_comb begin
    hiView   = '0;
    statView = '0;
    enView   = '0;
    hiView[SLPTYP_MSB:SLPTYP_LSB] = slpTypeQ;
    statView[EVT_BIT] = statusQ;
    enView[EVT_BIT]   = enableQ;
  end

  always_comb begin
    unique case (strobes.rdSel)
      RD_CTRL_HI: regRdata = hiView;
      RD_STATUS:  regRdata = statView;
      RD_ENABLE:  regRdata = enView;
      default:    regRdata = '0;
    endcase
  end

  // R3: trigger sets status next cycle
  a_r3_trig_sets: assert property (@(posedge clk) disable iff (!rstN)
    strobes.slpTrig |=> statusQ);

  // R7: write-one clears status
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrStatus && !strobes.slpTrig) |=> !statusQ);

  // R8: sleep-type write without trigger keeps status
  a_r8_type_no_effect: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrSlpType && !strobes.slpTrig && !strobes.clrStatus) |=> $stable(statusQ));

  // R4: sleep-enable bit position never reads back set
  a_r4_slpen_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdSel == RD_CTRL_HI) |-> !regRdata[EVT_BIT]);

endmodule

// File: rtl/sleep_smi_regs.sv
module sleep_smi_regs
  import sleep_smi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              smiOut
);

  localparam int SLP_EN_BIT = 5;
  localparam int EVT_BIT    = 5;

  strobe_t strobes;
  logic    statusQ, enableQ;

  sleep_smi_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SLP_EN_BIT(SLP_EN_BIT), .EVT_BIT(EVT_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regRd(regRd), .regWdata(regWdata), .strobes(strobes)
  );

  sleep_smi_dp #(
    .DATA_W(DATA_W), .SLPTYP_LSB(2), .SLPTYP_W(3), .EVT_BIT(EVT_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWdata(regWdata),
    .regRdata(regRdata), .statusQ(statusQ), .enableQ(enableQ)
  );

  assign smiOut = statusQ && enableQ;

  // R6: SMI rises only when a trigger or enable write just happened
  a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(smiOut) |-> $past(strobes.slpTrig || strobes.wrEnable));

  // R10: idle bus returns zero
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !regRd |-> regRdata == '0);

endmodule

// File: tb/sleep_smi_regs_tb.sv
module sleep_smi_regs_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regAddr = '0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       smiOut;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  sleep_smi_regs u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .smiOut(smiOut)
  );

  // {isWr, addr, data, expRdata, expSmi}
  localparam int NV = 30;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 8'h60, 8'h00, 8'h00, 1'b0},
    {1'b1, 8'h61, 8'h1C, 8'h00, 1'b0},
    {1'b0, 8'h61, 8'h00, 8'h1C, 1'b0},
    {1'b0, 8'h64, 8'h00, 8'h00, 1'b0},
    {1'b1, 8'h61, 8'hFF, 8'h00, 1'b0},
    {1'b0, 8'h61, 8'h00, 8'h1C, 1'b0},
    {1'b0, 8'h64, 8'h00, 8'h20, 1'b0},
    {1'b1, 8'h66, 8'hFF, 8'h00, 1'b1},
    {1'b0, 8'h66, 8'h00, 8'h20, 1'b1},
    {1'b1, 8'h64, 8'hDF, 8'h00, 1'b1},
    {1'b0, 8'h64, 8'h00, 8'h20, 1'b1},
    {1'b1, 8'h64, 8'h20, 8'h00, 1'b0},
    {1'b0, 8'h64, 8'h00, 8'h00, 1'b0},
    {1'b1, 8'h61, 8'h08, 8'h00, 1'b0},
    {1'b0, 8'h61, 8'h00, 8'h08, 1'b0},
    {1'b1, 8'h61, 8'h20, 8'h00, 1'b1},
    {1'b0, 8'h61, 8'h00, 8'h00, 1'b1},
    {1'b1, 8'h61, 8'h14, 8'h00, 1'b1},
    {1'b0, 8'h64, 8'h00, 8'h20, 1'b1},
    {1'b1, 8'h66, 8'h00, 8'h00, 1'b0},
    {1'b0, 8'h64, 8'h00, 8'h20, 1'b0},
    {1'b1, 8'h66, 8'h20, 8'h00, 1'b1},
    {1'b1, 8'h64, 8'hFF, 8'h00, 1'b0},
    {1'b1, 8'h60, 8'hFF, 8'h00, 1'b0},
    {1'b0, 8'h60, 8'h00, 8'h00, 1'b0},
    {1'b1, 8'h65, 8'hFF, 8'h00, 1'b0},
    {1'b0, 8'h65, 8'h00, 8'h00, 1'b0},
    {1'b1, 8'h62, 8'hFF, 8'h00, 1'b0},
    {1'b0, 8'h64, 8'h00, 8'h00, 1'b0},
    {1'b0, 8'h61, 8'h00, 8'h14, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wrOp(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0; regAddr = '0; regWdata = '0;
  endtask

  task automatic rdOp(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    regRd = 1'b0; regAddr = '0;
  endtask

  initial begin
    #50000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    check("R1 smi after reset (held)", {7'd0, smiOut}, 8'h00);
    rstN = 1'b1;
    rdOp(8'h64, rd); check("R1 status reset", rd, 8'h00);
    rdOp(8'h66, rd); check("R1 enable reset", rd, 8'h00);
    rdOp(8'h61, rd); check("R1 ctrl reset", rd, 8'h00);

    // vector walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      if (v[25]) begin
        wrOp(v[24:17], v[16:9]);
      end else begin
        rdOp(v[24:17], rd);
        check($sformatf("R2-R9 vec%0d rdata", i), rd, v[8:1]);
      end
      check($sformatf("R6 vec%0d smi", i), {7'd0, smiOut}, {7'd0, v[0]});
    end

    // R10: read strobe low returns zero even at a populated offset
    wrOp(8'h66, 8'h20);
    wrOp(8'h61, 8'h3C);
    @(negedge clk);
    regAddr = 8'h64; regRd = 1'b0;
    #1 check("R10 idle rdata", regRdata, 8'h00);
    regAddr = '0;

    // trigger, clear, trigger back to back: R3 R7 R6
    wrOp(8'h64, 8'h20);
    check("R7 clear before adj test", {7'd0, smiOut}, 8'h00);
    wrOp(8'h61, 8'h20);
    check("R3 adj trigger", {7'd0, smiOut}, 8'h01);
    wrOp(8'h64, 8'h20);
    check("R7 adj clear", {7'd0, smiOut}, 8'h00);
    wrOp(8'h61, 8'h20);
    check("R6 adj retrigger", {7'd0, smiOut}, 8'h01);

    // mid-run reset: R1
    @(negedge clk); rstN = 1'b0;
    #1 check("R1 smi in reset", {7'd0, smiOut}, 8'h00);
    @(negedge clk); rstN = 1'b1;
    rdOp(8'h64, rd); check("R1 status after rerst", rd, 8'h00);
    rdOp(8'h66, rd); check("R1 enable after rerst", rd, 8'h00);
    rdOp(8'h61, rd); check("R1 ctrl after rerst", rd, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule